// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block links a card-side data line and a controller-side data line. Both lines are open-drain and rest high through pull-ups. Whichever line is first seen falling takes the master role. After a fixed delay the block pulls the other line, the slave, low, so the low level is copied across. When the master goes high again, the block stops pulling low and briefly drives the slave high to give it a fast rising edge. It then waits until both lines are high before it accepts a new falling edge.

The block sees both lines as levels that are already synchronized to its clock. It controls each line through two enables: a pull-low enable and an active pull-up enable. The delay is set in clock cycles by `EDGE_DLY`. For example, 4 cycles at 20 MHz gives about 200 ns, which leaves plenty of margin for line activity up to 1 MHz. A design with several data lines uses one instance per line.

Top module: `line_repeater`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle, and after that edge all four enables are 0.
- R2: While both lines are high and no transfer is in progress, all four enables stay 0.
- R3: When a line is first sampled low after being sampled high, and the block is idle, that line becomes master. The slave's pull-low enable turns on exactly `EDGE_DLY` clock edges after the edge at which the master's low level was first sampled.
- R4: If both lines are first sampled low at the same edge, the controller-side line becomes master and only the card-side line is pulled low.
- R5: After a master is elected, a falling level on the slave line does not start a new election. The block never asserts either enable of the master line.
- R6: At the edge where the master is first sampled high during the pull-low phase, the slave's pull-low enable turns off and its pull-up enable turns on for exactly `EDGE_DLY` cycles.
- R7: At most one of the four enables is asserted at any time.
- R8: If the master is sampled high again before the delay has expired, the slave is never driven.
- R9: After the pull-up pulse ends, a new election starts only once both lines have been sampled high. A falling edge that occurs while either line is still low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_lvl | input | 1 | Synchronized level of the card-side line |
| host_lvl | input | 1 | Synchronized level of the controller-side line |
| card_pull_lo | output | 1 | Pull the card-side line low |
| card_pull_hi | output | 1 | Active pull-up pulse on the card-side line |
| host_pull_lo | output | 1 | Pull the controller-side line low |
| host_pull_hi | output | 1 | Active pull-up pulse on the controller-side line |

## Verification
The bench models each line as a wired-AND of an external pull-down and the block's own pull-low enable. Because of this, the slave really reads low while it is being driven, which puts the edge lockout under test.

Random transfers with either master and random low times check that the delay is exact and that the pulse has the right length in both directions. Short random glitches, shorter than the delay, check that an early release cancels the copy. Directed cases cover the following:
- a fall on both lines in the same cycle, which tells the tie-break apart;
- a slave held low externally across the pulse while the master falls again, which separates correct re-arming from early re-arming;
- a reset in the middle of a transfer.

// File: rtl/line_repeater.sv
module line_repeater #(
  parameter int EDGE_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_lvl,
  input  logic host_lvl,
  output logic card_pull_lo,
  output logic card_pull_hi,
  output logic host_pull_lo,
  output logic host_pull_hi
);

  localparam int CW = $clog2(EDGE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGE_DLY - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_PULSE, S_REARM} st_t;

  st_t           st;
  logic          host_master;
  logic [CW-1:0] cnt;
  logic          card_q, host_q;

  wire card_fall  = card_q & ~card_lvl;
  wire host_fall  = host_q & ~host_lvl;
  wire master_lvl = host_master ? host_lvl : card_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      host_master <= 1'b0;
      card_q      <= 1'b1;
      host_q      <= 1'b1;
    end else begin
      card_q <= card_lvl;
      host_q <= host_lvl;
      case (st)
        S_IDLE:
          if (host_fall | card_fall) begin
            host_master <= host_fall;
            cnt         <= '0;
            st          <= S_WAIT;
          end
        S_WAIT:
          if (master_lvl)       st <= S_REARM;
          else if (cnt == LAST) st <= S_HOLD;
          else                  cnt <= cnt + 1'b1;
        S_HOLD:
          if (master_lvl) begin
            cnt <= '0;
            st  <= S_PULSE;
          end
        S_PULSE:
          if (cnt == LAST) st <= S_REARM;
          else             cnt <= cnt + 1'b1;
        S_REARM:
          if (card_lvl & host_lvl) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire drive_lo = (st == S_HOLD);
  wire drive_hi = (st == S_PULSE);

  assign card_pull_lo = drive_lo &  host_master;
  assign host_pull_lo = drive_lo & ~host_master;
  assign card_pull_hi = drive_hi &  host_master;
  assign host_pull_hi = drive_hi & ~host_master;

endmodule

module line_repeater_chk #(
  parameter int EDGE_DLY = 4
) (
  input logic clk,
  input logic rst_n,
  input logic card_lvl,
  input logic host_lvl,
  input logic card_pull_lo,
  input logic card_pull_hi,
  input logic host_pull_lo,
  input logic host_pull_hi
);

  int hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= 0;
    else        hi_run <= (card_pull_hi | host_pull_hi) ? hi_run + 1 : 0;
  end

  // R7
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_pull_lo, card_pull_hi, host_pull_lo, host_pull_hi}));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !(card_pull_lo | card_pull_hi | host_pull_lo | host_pull_hi));

  // R3
  card_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pull_lo) |-> !$past(host_lvl));

  // R3
  host_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pull_lo) |-> !$past(card_lvl));

  // R6
  card_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pull_hi) |-> $past(card_pull_lo));

  // R6
  host_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pull_hi) |-> $past(host_pull_lo));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= EDGE_DLY);

endmodule

bind line_repeater line_repeater_chk #(.EDGE_DLY(EDGE_DLY)) chk_i (.*);

// File: tb/line_repeater_test.sv
module line_repeater_test;
  localparam int D = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic card_ext = 1'b0, host_ext = 1'b0;
  wire  card_lvl, host_lvl;
  wire  card_pull_lo, card_pull_hi, host_pull_lo, host_pull_hi;
  int   total = 0, failed = 0;

  assign card_lvl = ~(card_ext | card_pull_lo);
  assign host_lvl = ~(host_ext | host_pull_lo);

  line_repeater #(.EDGE_DLY(D)) uut (
    .clk(clk), .rst_n(rst_n), .card_lvl(card_lvl), .host_lvl(host_lvl),
    .card_pull_lo(card_pull_lo), .card_pull_hi(card_pull_hi),
    .host_pull_lo(host_pull_lo), .host_pull_hi(host_pull_hi));

  function automatic logic exp_lo(int n); return n >= D + 1; endfunction
  function automatic logic exp_hi(int p); return p >= 1 && p <= D; endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic all_quiet(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      step();
      chk(req, card_pull_lo | card_pull_hi | host_pull_lo | host_pull_hi, 1'b0);
    end
  endtask

  task automatic xfer(bit host_m, int hold);
    if (host_m) host_ext = 1'b1; else card_ext = 1'b1;
    for (int n = 1; n <= hold; n++) begin
      step();
      chk("R3", host_m ? card_pull_lo : host_pull_lo, exp_lo(n));
      chk("R5", host_m ? (host_pull_lo | host_pull_hi) : (card_pull_lo | card_pull_hi), 1'b0);
    end
    if (host_m) host_ext = 1'b0; else card_ext = 1'b0;
    for (int p = 1; p <= D + 2; p++) begin
      step();
      chk("R6", host_m ? card_pull_hi : host_pull_hi, exp_hi(p));
      chk("R6", host_m ? card_pull_lo : host_pull_lo, 1'b0);
      chk("R5", host_m ? (host_pull_lo | host_pull_hi) : (card_pull_lo | card_pull_hi), 1'b0);
    end
  endtask

  task automatic glitch(bit host_m, int len);
    if (host_m) host_ext = 1'b1; else card_ext = 1'b1;
    all_quiet("R8", len);
    if (host_m) host_ext = 1'b0; else card_ext = 1'b0;
    all_quiet("R8", D + 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    all_quiet("R1", 3);
    rst_n = 1'b1;
    all_quiet("R2", 4);

    xfer(1'b1, D + 3);
    xfer(1'b0, D + 6);

    // R4 tie-break
    host_ext = 1'b1; card_ext = 1'b1;
    for (int n = 1; n <= D + 3; n++) begin
      step();
      chk("R4", card_pull_lo, exp_lo(n));
      chk("R4", host_pull_lo | host_pull_hi, 1'b0);
    end
    host_ext = 1'b0; card_ext = 1'b0;
    for (int p = 1; p <= D + 2; p++) begin
      step();
      chk("R4", card_pull_hi, exp_hi(p));
    end

    glitch(1'b1, D - 1);
    glitch(1'b0, 1);

    // R9 re-arm needs both lines high
    host_ext = 1'b1;
    repeat (D + 2) step();
    chk("R3", card_pull_lo, 1'b1);
    host_ext = 1'b0; card_ext = 1'b1;
    repeat (D + 2) step();
    host_ext = 1'b1;
    all_quiet("R9", 10);
    card_ext = 1'b0;
    all_quiet("R9", 5);
    host_ext = 1'b0;
    all_quiet("R9", 3);
    xfer(1'b1, D + 2);

    // R1 reset in the middle of a transfer
    host_ext = 1'b1;
    repeat (D + 2) step();
    chk("R1", card_pull_lo, 1'b1);
    rst_n = 1'b0;
    all_quiet("R1", 2);
    rst_n = 1'b1;
    host_ext = 1'b0;
    all_quiet("R1", 3);

    for (int i = 0; i < 200; i++) begin
      int kind = int'($urandom_range(0, 3));
      bit m = bit'($urandom_range(0, 1));
      if (kind < 3) xfer(m, int'($urandom_range(D + 2, D + 20)));
      else          glitch(m, int'($urandom_range(1, D - 1)));
      all_quiet("R2", int'($urandom_range(1, 5)));
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule